// File: doc/BRIEF.md
# Circular and Bit-Reversed Address Generator

This block computes memory addresses for a signal-processing data path. It keeps four buffer descriptors. Each descriptor holds a start address, a length and a running index. Each cycle the block takes one operation. The operation either loads a descriptor field or performs one access through the selected descriptor. For an access, the block returns the effective address and the pointer value that results, and it echoes the access-size tag for the memory stage. The new pointer is written back in the same cycle, so the next operation on that descriptor already sees it.

An access has one of three forms. Pre-modify uses the modified pointer as the address. Post-modify uses the old pointer and then advances it. Bit-reverse steps the low bits of the pointer with the carry running from the high bit toward the low bit, which produces the reordered sequence that radix-2 FFT stages need. Pre- and post-modify wrap the pointer inside the buffer when the length is non-zero. The buffer may start at any address and have any length. A length of zero gives plain linear addressing. A modifier whose magnitude is larger than a non-zero length is refused and reported.

The block has no state machine. Decoding is one `unique case` over the enumerated operation codes: NOP, SET_BASE, SET_LEN, SET_IDX, PRE, POST and BREV. A decoded operation takes effect at the next rising edge, and no operation spans more than one cycle.

Top module: `circ_agu`

## Requirements
- R1: Four descriptors exist, each with its own base, length and index, and reset clears them all to zero. `op_i` codes 1, 2 and 3 (SET_BASE, SET_LEN, SET_IDX) write `mod_i` into the base, the length or the index of the descriptor named by `sel_i`. No other descriptor changes.
- R2: For PRE (code 4) and POST (code 5) with a non-zero length, the block first forms idx+mod, with `mod_i` taken as two's complement. If the modifier is not negative and the sum is at or above base+length, length is subtracted. If the modifier is negative and the sum is below base, length is added. This holds for any base and any length.
- R3: PRE outputs the wrapped new pointer as `addr_o`. POST outputs the old index as `addr_o`. For both, `ptr_o` is the new pointer.
- R4: BREV (code 6) outputs the old index as `addr_o`. The low BREV_W bits of the new pointer are rev(rev(idx_low)+rev(mod_low)) modulo 2^BREV_W, where rev mirrors the bit order. The upper index bits are kept, and the length is ignored.
- R5: On a valid access, `size_o` repeats the `size_i` of that access. The encodings are 0 single, 1 double, 2 quad.
- R6: Outputs are registered one cycle after the operation. The updated pointer is the index that the next operation on the same descriptor uses.
- R7: For PRE or POST with a non-zero length and |mod| > length, `err_o` is 1 and `valid_o` is 0. The index is not changed, and `addr_o` and `ptr_o` both show the old index. |mod| equal to the length is accepted.
- R8: With length zero, PRE and POST give idx+mod modulo 2^AW with no wrap.
- R9: NOP (code 0) and the SET operations give `valid_o`=0 and `err_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_i | input | 3 | Operation code |
| sel_i | input | 2 | Descriptor select |
| mod_i | input | AW | Modifier (two's complement) or load value |
| size_i | input | 2 | Access size tag |
| valid_o | output | 1 | Access accepted and pointer updated |
| err_o | output | 1 | Modifier refused |
| addr_o | output | AW | Effective address |
| ptr_o | output | AW | Resulting pointer |
| size_o | output | 2 | Echoed access size |

## Verification
The patterns cover several cases. Forward and backward steps inside the buffer are separated from steps that cross the top or bottom edge, including a sum landing exactly on base+length. A modifier equal to the length, which is accepted, is separated from one just larger, which is refused, for both signs. A follow-up access then shows that a refused step left the index unchanged. Linear runs across the 2^AW boundary separate length-zero behaviour from wrapped behaviour. A bit-reverse walk from zero and a step from the all-ones field show the reversed carry and that the upper bits are preserved. An untouched descriptor and a mid-run reset show that the descriptors are independent and that reset clears them.

// File: rtl/circ_agu_pkg.sv
package circ_agu_pkg;
    typedef enum logic [2:0] {
        OP_NOP      = 3'd0,
        OP_SET_BASE = 3'd1,
        OP_SET_LEN  = 3'd2,
        OP_SET_IDX  = 3'd3,
        OP_PRE      = 3'd4,
        OP_POST     = 3'd5,
        OP_BREV     = 3'd6
    } agu_op_e;

    typedef enum logic [1:0] {
        SZ_SINGLE = 2'd0,
        SZ_DOUBLE = 2'd1,
        SZ_QUAD   = 2'd2,
        SZ_RSVD   = 2'd3
    } agu_size_e;
endpackage

// File: rtl/circ_agu_regs.sv
module circ_agu_regs #(
    parameter int AW    = 16,
    parameter int NDESC = 4,
    parameter int SW    = $clog2(NDESC)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] sel,
    input  logic          we_base,
    input  logic          we_len,
    input  logic          we_idx,
    input  logic [AW-1:0] wdata,
    input  logic [AW-1:0] idx_wdata,
    output logic [AW-1:0] rd_base,
    output logic [AW-1:0] rd_len,
    output logic [AW-1:0] rd_idx
);
    logic [AW-1:0] base_q [NDESC];
    logic [AW-1:0] len_q  [NDESC];
    logic [AW-1:0] idx_q  [NDESC];

    for (genvar g = 0; g < NDESC; g++) begin : g_desc
        logic hit;
        assign hit = (sel == SW'(g));
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_q[g] <= '0;
                len_q[g]  <= '0;
                idx_q[g]  <= '0;
            end else begin
                if (hit && we_base) base_q[g] <= wdata;
                if (hit && we_len)  len_q[g]  <= wdata;
                if (hit && we_idx)  idx_q[g]  <= idx_wdata;
            end
        end
    end

    assign rd_base = base_q[sel];
    assign rd_len  = len_q[sel];
    assign rd_idx  = idx_q[sel];
endmodule

// File: rtl/circ_agu_step.sv
module circ_agu_step #(
    parameter int AW     = 16,
    parameter int BREV_W = 4
) (
    input  logic [AW-1:0] idx,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] len,
    input  logic [AW-1:0] mod,
    input  logic          brev,
    output logic [AW-1:0] nxt,
    output logic          err
);
    localparam int EW = AW + 2;
    localparam logic [AW-1:0] FMASK = AW'((1 << BREV_W) - 1);

    function automatic logic [BREV_W-1:0] mirror(input logic [BREV_W-1:0] v);
        logic [BREV_W-1:0] r;
        for (int i = 0; i < BREV_W; i++) r[i] = v[BREV_W-1-i];
        return r;
    endfunction

    logic signed [EW-1:0] sum, lim, lo_b, adj;
    logic [AW:0]          mag;
    logic [BREV_W-1:0]    r_sum;
    logic [AW-1:0]        wrap_nxt, brev_nxt;
    logic                 neg;

    always_comb begin
        neg  = mod[AW-1];
        sum  = $signed({2'b00, idx}) + $signed({{2{mod[AW-1]}}, mod});
        lim  = $signed({2'b00, base}) + $signed({2'b00, len});
        lo_b = $signed({2'b00, base});
        adj  = sum;
        if (len != '0) begin
            if (!neg && (sum >= lim))     adj = sum - $signed({2'b00, len});
            else if (neg && (sum < lo_b)) adj = sum + $signed({2'b00, len});
        end
        wrap_nxt = adj[AW-1:0];

        r_sum    = mirror(idx[BREV_W-1:0]) + mirror(mod[BREV_W-1:0]);
        brev_nxt = (idx & ~FMASK) | AW'(mirror(r_sum));

        mag = neg ? (~{1'b1, mod} + 1'b1) : {1'b0, mod};
        err = !brev && (len != '0) && (mag > {1'b0, len});
        nxt = brev ? brev_nxt : wrap_nxt;
    end
endmodule

// File: rtl/circ_agu.sv
module circ_agu
    import circ_agu_pkg::*;
#(
    parameter int AW     = 16,
    parameter int NDESC  = 4,
    parameter int BREV_W = 4,
    parameter int SW     = $clog2(NDESC)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    op_i,
    input  logic [SW-1:0] sel_i,
    input  logic [AW-1:0] mod_i,
    input  logic [1:0]    size_i,
    output logic          valid_o,
    output logic          err_o,
    output logic [AW-1:0] addr_o,
    output logic [AW-1:0] ptr_o,
    output logic [1:0]    size_o
);
    agu_op_e       op;
    logic          set_b, set_l, set_i, is_addr, is_pre, is_brev, upd;
    logic [AW-1:0] cur_base, cur_len, cur_idx, step_nxt, idx_wd;
    logic          step_err;

    assign op = agu_op_e'(op_i);

    always_comb begin
        set_b   = 1'b0;
        set_l   = 1'b0;
        set_i   = 1'b0;
        is_addr = 1'b0;
        is_pre  = 1'b0;
        is_brev = 1'b0;
        unique case (op)
            OP_SET_BASE: set_b = 1'b1;
            OP_SET_LEN:  set_l = 1'b1;
            OP_SET_IDX:  set_i = 1'b1;
            OP_PRE:      begin is_addr = 1'b1; is_pre = 1'b1; end
            OP_POST:     is_addr = 1'b1;
            OP_BREV:     begin is_addr = 1'b1; is_brev = 1'b1; end
            default:     ;
        endcase
    end

    assign upd    = is_addr && !step_err;
    assign idx_wd = set_i ? mod_i : step_nxt;

    circ_agu_regs #(.AW(AW), .NDESC(NDESC), .SW(SW)) u_regs (
        .clk(clk), .rst_n(rst_n), .sel(sel_i),
        .we_base(set_b), .we_len(set_l), .we_idx(set_i || upd),
        .wdata(mod_i), .idx_wdata(idx_wd),
        .rd_base(cur_base), .rd_len(cur_len), .rd_idx(cur_idx)
    );

    circ_agu_step #(.AW(AW), .BREV_W(BREV_W)) u_step (
        .idx(cur_idx), .base(cur_base), .len(cur_len), .mod(mod_i),
        .brev(is_brev), .nxt(step_nxt), .err(step_err)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            err_o   <= 1'b0;
            addr_o  <= '0;
            ptr_o   <= '0;
            size_o  <= SZ_SINGLE;
        end else begin
            valid_o <= upd;
            err_o   <= is_addr && step_err;
            if (is_addr) begin
                addr_o <= (is_pre && upd) ? step_nxt : cur_idx;
                ptr_o  <= upd ? step_nxt : cur_idx;
                size_o <= size_i;
            end
        end
    end
endmodule

// File: rtl/circ_agu_chk.sv
module circ_agu_chk #(
    parameter int AW = 16,
    parameter int SW = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic [2:0]    op_i,
    input logic [SW-1:0] sel_i,
    input logic [AW-1:0] mod_i,
    input logic [1:0]    size_i,
    input logic          valid_o,
    input logic          err_o,
    input logic [AW-1:0] addr_o,
    input logic [AW-1:0] ptr_o,
    input logic [1:0]    size_o,
    input logic [AW-1:0] cur_idx,
    input logic [AW-1:0] cur_base,
    input logic [AW-1:0] cur_len
);
    logic [AW:0] top_q;
    assign top_q = {1'b0, cur_base} + {1'b0, cur_len};

    AST_SIZE_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> size_o == $past(size_i)); // R5
    AST_PRE_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && $past(op_i) == 3'd4) |-> addr_o == ptr_o); // R3
    AST_POST_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && $past(op_i) != 3'd4) |-> addr_o == $past(cur_idx)); // R3
    AST_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && $past(op_i) != 3'd6 && $past(cur_len) != '0
         && $past(cur_idx) >= $past(cur_base) && {1'b0, $past(cur_idx)} < $past(top_q))
        |-> (ptr_o >= $past(cur_base) && {1'b0, ptr_o} < $past(top_q))); // R2
    AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (!valid_o && ptr_o == $past(cur_idx) && addr_o == $past(cur_idx))); // R7
    AST_NEXT_USE: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && sel_i == $past(sel_i)) |-> cur_idx == ptr_o); // R6
    AST_LINEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && $past(cur_len) == '0 && $past(op_i) != 3'd6)
        |-> ptr_o == AW'($past(cur_idx) + $past(mod_i))); // R8
    AST_QUIET_OPS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(op_i) < 3'd4) |-> (!valid_o && !err_o)); // R9
endmodule

bind circ_agu circ_agu_chk #(.AW(AW), .SW(SW)) u_chk (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .sel_i(sel_i), .mod_i(mod_i),
    .size_i(size_i), .valid_o(valid_o), .err_o(err_o), .addr_o(addr_o),
    .ptr_o(ptr_o), .size_o(size_o), .cur_idx(cur_idx), .cur_base(cur_base),
    .cur_len(cur_len)
);

// File: tb/circ_agu_tb.sv
module circ_agu_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int NV = 25;

    typedef struct packed {
        logic [3:0]  req;
        logic [2:0]  op;
        logic [1:0]  sel;
        logic [15:0] md;
        logic [1:0]  sz;
        logic        chk;
        logic        v;
        logic        e;
        logic [15:0] a;
        logic [15:0] p;
    } vec_t;

    localparam vec_t TBL [NV] = '{
        '{4'd9, 3'd0, 2'd0, 16'd0,      2'd0, 1'b0, 1'b0, 1'b0, 16'h0,   16'h0},   // R9 NOP
        '{4'd1, 3'd1, 2'd0, 16'd100,    2'd0, 1'b0, 1'b0, 1'b0, 16'h0,   16'h0},   // R1 base
        '{4'd1, 3'd2, 2'd0, 16'd10,     2'd0, 1'b0, 1'b0, 1'b0, 16'h0,   16'h0},   // R1 length
        '{4'd1, 3'd3, 2'd0, 16'd105,    2'd0, 1'b0, 1'b0, 1'b0, 16'h0,   16'h0},   // R1 index
        '{4'd3, 3'd5, 2'd0, 16'd3,      2'd0, 1'b1, 1'b1, 1'b0, 16'd105, 16'd108}, // R3 post
        '{4'd2, 3'd5, 2'd0, 16'd3,      2'd1, 1'b1, 1'b1, 1'b0, 16'd108, 16'd101}, // R2 up wrap
        '{4'd2, 3'd4, 2'd0, 16'hFFFE,   2'd2, 1'b1, 1'b1, 1'b0, 16'd109, 16'd109}, // R2 down wrap
        '{4'd2, 3'd4, 2'd0, 16'd1,      2'd0, 1'b1, 1'b1, 1'b0, 16'd100, 16'd100}, // R2 exact top
        '{4'd7, 3'd4, 2'd0, 16'd10,     2'd2, 1'b1, 1'b1, 1'b0, 16'd100, 16'd100}, // R7 equal ok
        '{4'd7, 3'd5, 2'd0, 16'd11,     2'd1, 1'b1, 1'b0, 1'b1, 16'd100, 16'd100}, // R7 too big
        '{4'd7, 3'd4, 2'd0, 16'hFFF5,   2'd1, 1'b1, 1'b0, 1'b1, 16'd100, 16'd100}, // R7 too big neg
        '{4'd6, 3'd5, 2'd0, 16'd0,      2'd1, 1'b1, 1'b1, 1'b0, 16'd100, 16'd100}, // R6 kept
        '{4'd1, 3'd4, 2'd3, 16'd0,      2'd0, 1'b1, 1'b1, 1'b0, 16'd0,   16'd0},   // R1 untouched
        '{4'd1, 3'd3, 2'd1, 16'd65530,  2'd0, 1'b0, 1'b0, 1'b0, 16'h0,   16'h0},   // R1 index
        '{4'd8, 3'd4, 2'd1, 16'd10,     2'd2, 1'b1, 1'b1, 1'b0, 16'd4,   16'd4},   // R8 linear up
        '{4'd8, 3'd5, 2'd1, 16'hFFFB,   2'd1, 1'b1, 1'b1, 1'b0, 16'd4,   16'd65535}, // R8 linear down
        '{4'd1, 3'd3, 2'd2, 16'h0120,   2'd0, 1'b0, 1'b0, 1'b0, 16'h0,   16'h0},   // R1 index
        '{4'd4, 3'd6, 2'd2, 16'd8,      2'd2, 1'b1, 1'b1, 1'b0, 16'h120, 16'h128}, // R4
        '{4'd4, 3'd6, 2'd2, 16'd8,      2'd2, 1'b1, 1'b1, 1'b0, 16'h128, 16'h124}, // R4
        '{4'd4, 3'd6, 2'd2, 16'd8,      2'd2, 1'b1, 1'b1, 1'b0, 16'h124, 16'h12C}, // R4
        '{4'd4, 3'd6, 2'd2, 16'd8,      2'd0, 1'b1, 1'b1, 1'b0, 16'h12C, 16'h122}, // R4
        '{4'd1, 3'd3, 2'd2, 16'h012F,   2'd0, 1'b0, 1'b0, 1'b0, 16'h0,   16'h0},   // R1 index
        '{4'd4, 3'd6, 2'd2, 16'd8,      2'd1, 1'b1, 1'b1, 1'b0, 16'h12F, 16'h120}, // R4 field wrap
        '{4'd2, 3'd5, 2'd0, 16'hFFFF,   2'd2, 1'b1, 1'b1, 1'b0, 16'd100, 16'd109}, // R2 below base
        '{4'd5, 3'd6, 2'd2, 16'd1,      2'd1, 1'b1, 1'b1, 1'b0, 16'h120, 16'h121}  // R5 R4
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    op_i = '0;
    logic [1:0]    sel_i = '0;
    logic [AW-1:0] mod_i = '0;
    logic [1:0]    size_i = '0;
    logic          valid_o, err_o;
    logic [AW-1:0] addr_o, ptr_o;
    logic [1:0]    size_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    circ_agu u_dut (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .sel_i(sel_i), .mod_i(mod_i),
        .size_i(size_i), .valid_o(valid_o), .err_o(err_o), .addr_o(addr_o),
        .ptr_o(ptr_o), .size_o(size_o)
    );

    task automatic run_vec(input vec_t t, input int row);
        logic ok;
        op_i = t.op; sel_i = t.sel; mod_i = t.md; size_i = t.sz;
        @(negedge clk);
        ok = (valid_o == t.v) && (err_o == t.e);
        if (t.chk) ok = ok && (addr_o == t.a) && (ptr_o == t.p);
        if (t.chk && t.v) ok = ok && (size_o == t.sz);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL R%0d row %0d: got v=%0d e=%0d a=%h p=%h s=%0d exp v=%0d e=%0d a=%h p=%h s=%0d",
                     t.req, row, valid_o, err_o, addr_o, ptr_o, size_o,
                     t.v, t.e, t.a, t.p, t.sz);
        end
    endtask

    task automatic check_val(input string tag, input logic [AW-1:0] got, input logic [AW-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state of outputs
        check_val("R9 reset valid", AW'(valid_o), '0);
        check_val("R9 reset err", AW'(err_o), '0);
        check_val("R1 reset addr", addr_o, '0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < NV; i++) run_vec(TBL[i], i);

        // R1 reset in mid-use clears descriptors
        op_i = 3'd0;
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        run_vec('{4'd1, 3'd4, 2'd0, 16'd0, 2'd0, 1'b1, 1'b1, 1'b0, 16'd0, 16'd0}, 100);
        // R8 zero length after reset: linear step from zero
        run_vec('{4'd8, 3'd4, 2'd0, 16'd7, 2'd2, 1'b1, 1'b1, 1'b0, 16'd7, 16'd7}, 101);
        // R6 back-to-back steps on the same descriptor
        run_vec('{4'd6, 3'd5, 2'd0, 16'd7, 2'd1, 1'b1, 1'b1, 1'b0, 16'd7, 16'd14}, 102);

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule